// File: doc/BRIEF.md
# Twelve-Line GPIO Controller with Latched Level Interrupts

This block drives and samples twelve general-purpose pins behind a small 32-bit register interface. Software sets output values and per-line output enables, and reads the pin levels back after a two-flop synchroniser. Each line has a level interrupt detector whose polarity can be chosen: high-active or low-active. A detected level sets a sticky status bit. An enable mask decides which status bits reach the single active-high interrupt output.

Status bits hold level conditions, not edges. Writing a one to a status bit clears it for one cycle. If the pin is still at its active level, the bit sets again on the following cycle. A driver must therefore remove the interrupt source before it acknowledges. A 32-bit mux-control word is stored and driven out unchanged, for pad-multiplexing logic elsewhere.

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the output data, output enable, interrupt enable, both polarity registers, the status register and the mux word are zero, and `irq_o` is low.
- R2: Offsets 0x00 (output data) and 0x04 (output enable) are read/write. Bit n drives `pad_out[n]` and `pad_oe[n]`. Bits 31:12 read as zero and ignore writes.
- R3: Offset 0x08 reads the pin levels after the two-flop synchroniser, with line n at bit n and bits 31:12 zero. Writes to 0x08 have no effect.
- R4: The polarity bit for line n lies at bit 4*(n mod 8). Lines 0–7 use the register at offset 0x10 and lines 8–11 use the register at 0x18. A bit value of 0 means the line is active while the synchronised pin is high, and 1 means it is active while the pin is low. All other bits of both registers read zero.
- R5: Status bit n (offset 0x0C) sets while line n is active and stays set after the line goes inactive.
- R6: Writing 1 to status bit n clears it at that clock edge, and writing 0 leaves it unchanged. If line n is still active, the bit is set again one cycle after the clear.
- R7: `irq_o` is high exactly when the status register AND the interrupt enable register (offset 0x14, 1 = unmasked) is nonzero. Status bits latch whatever the enable setting.
- R8: Offset 0x1C stores a full 32-bit word, which is driven on `mux_sel` and read back unchanged.
- R9: Read data appears on `bus_rdata` one clock after the address is presented. Offsets other than the eight word offsets 0x00–0x1C read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pad_in | input | 12 | Asynchronous pin levels |
| pad_out | output | 12 | Output data towards the pads |
| pad_oe | output | 12 | Per-line output enable (1 = drive) |
| mux_sel | output | 32 | Stored pin-mux control word |
| irq_o | output | 1 | Combined active-high interrupt |

## Verification
The collision that matters is an acknowledge that lands while the line is still active. At that clock edge the clear wins. On the next edge the level detector sets the bit again. The bench holds a pin at its active level with its interrupt unmasked and writes a one to its status bit. It then watches `irq_o` at the two falling edges after the write: the output must read low and then high. Writing a zero in the same state must leave `irq_o` high.

// File: rtl/gpio_lvl_pkg.sv
// Package: shared sizes and register offsets of the level-interrupt GPIO block.
// Assumes word-aligned byte addresses; any other address is unmapped.
package gpio_lvl_pkg;
    localparam int unsigned GPIO_LINES = 12;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ADDR_W     = 8;
    localparam int unsigned POL_GROUP  = 8;   // lines per polarity register
    localparam int unsigned POL_STRIDE = 4;   // bit spacing of polarity bits

    localparam logic [ADDR_W-1:0] OFS_OUT  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_OE   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_IN   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_POL0 = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_POL1 = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_MUX  = 8'h1C;
endpackage

// File: rtl/gpio_lvl_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous pin levels.
// Assumes each bit is independent; no bus coherency across bits is claimed.
module gpio_lvl_sync #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    // Two sampling stages, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/gpio_lvl_status.sv
// Module: per-line level detector and sticky status with write-one-to-clear.
// Assumes clr_i is a one-cycle pulse per acknowledge; the clear wins over a
// set on the same edge, and a level still present sets the bit next edge.
module gpio_lvl_status #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o
);
    logic [W-1:0] active;
    logic [W-1:0] status_q;

    // Active condition: high level for pol 0, low level for pol 1.
    assign active = level_i ^ pol_i;

    // Sticky status: accumulate active lines, acknowledged bits drop first.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q | active) & ~clr_i;
    end

    assign status_o = status_q;

    // R5: without an acknowledge, no set bit may drop.
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R6: an acknowledged bit reads zero right after the clearing edge.
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((status_q & $past(clr_i)) == '0));

    // R6: an active line not being cleared is set on the next edge.
    p_level_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active != '0) |=> (((status_q | $past(clr_i)) & $past(active)) == $past(active)));
endmodule

// File: rtl/gpio_lvl_ctrl.sv
// Module: twelve-line GPIO controller with latched level interrupts.
// Holds the register file, decodes single-cycle writes, returns read data
// one clock later and combines masked status into one interrupt line.
// Assumes LINES <= 2*POL_GROUP so that two polarity registers cover all lines.
module gpio_lvl_ctrl
    import gpio_lvl_pkg::*;
#(
    parameter int unsigned LINES = GPIO_LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LINES-1:0]  pad_in,
    output logic [LINES-1:0]  pad_out,
    output logic [LINES-1:0]  pad_oe,
    output logic [DATA_W-1:0] mux_sel,
    output logic              irq_o
);
    localparam int unsigned PAD_W = DATA_W - LINES;

    logic [LINES-1:0]  out_q, oe_q, ien_q, pol_q;
    logic [DATA_W-1:0] mux_q, rdata_q;
    logic [LINES-1:0]  level_s, status_s, clr_s;
    logic [DATA_W-1:0] pol0_view, pol1_view;
    logic              wr_out, wr_oe, wr_stat, wr_pol0, wr_ien, wr_pol1, wr_mux;

    // Write strobes per register.
    assign wr_out  = bus_wr_en && (bus_addr == OFS_OUT);
    assign wr_oe   = bus_wr_en && (bus_addr == OFS_OE);
    assign wr_stat = bus_wr_en && (bus_addr == OFS_STAT);
    assign wr_pol0 = bus_wr_en && (bus_addr == OFS_POL0);
    assign wr_ien  = bus_wr_en && (bus_addr == OFS_IEN);
    assign wr_pol1 = bus_wr_en && (bus_addr == OFS_POL1);
    assign wr_mux  = bus_wr_en && (bus_addr == OFS_MUX);

    gpio_lvl_sync #(.W(LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pad_in),
        .sync_o (level_s)
    );

    // Acknowledge mask: only a status write carries clear bits.
    assign clr_s = wr_stat ? bus_wdata[LINES-1:0] : '0;

    gpio_lvl_status #(.W(LINES)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level_s),
        .pol_i   (pol_q),
        .clr_i   (clr_s),
        .status_o(status_s)
    );

    // Plain read/write registers for pads, enables and mux word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            oe_q  <= '0;
            ien_q <= '0;
            mux_q <= '0;
        end else begin
            if (wr_out) out_q <= bus_wdata[LINES-1:0];
            if (wr_oe)  oe_q  <= bus_wdata[LINES-1:0];
            if (wr_ien) ien_q <= bus_wdata[LINES-1:0];
            if (wr_mux) mux_q <= bus_wdata;
        end
    end

    // Polarity bits are spread at every fourth bit over two registers.
    for (genvar n = 0; n < LINES; n++) begin : g_pol
        if (n < POL_GROUP) begin : g_lo
            // Polarity bit of a low-group line.
            always_ff @(posedge clk) begin
                if (!rst_n)       pol_q[n] <= 1'b0;
                else if (wr_pol0) pol_q[n] <= bus_wdata[POL_STRIDE*n];
            end
        end else begin : g_hi
            // Polarity bit of a high-group line.
            always_ff @(posedge clk) begin
                if (!rst_n)       pol_q[n] <= 1'b0;
                else if (wr_pol1) pol_q[n] <= bus_wdata[POL_STRIDE*(n-POL_GROUP)];
            end
        end
    end

    // Rebuild the two sparse polarity views for read-back.
    always_comb begin
        pol0_view = '0;
        pol1_view = '0;
        for (int n = 0; n < LINES; n++) begin
            if (n < POL_GROUP) pol0_view[POL_STRIDE*n] = pol_q[n];
            else               pol1_view[POL_STRIDE*(n-POL_GROUP)] = pol_q[n];
        end
    end

    // Registered read mux; unmapped addresses return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else begin
            case (bus_addr)
                OFS_OUT:  rdata_q <= {{PAD_W{1'b0}}, out_q};
                OFS_OE:   rdata_q <= {{PAD_W{1'b0}}, oe_q};
                OFS_IN:   rdata_q <= {{PAD_W{1'b0}}, level_s};
                OFS_STAT: rdata_q <= {{PAD_W{1'b0}}, status_s};
                OFS_POL0: rdata_q <= pol0_view;
                OFS_IEN:  rdata_q <= {{PAD_W{1'b0}}, ien_q};
                OFS_POL1: rdata_q <= pol1_view;
                OFS_MUX:  rdata_q <= mux_q;
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
    assign pad_out   = out_q;
    assign pad_oe    = oe_q;
    assign mux_sel   = mux_q;
    assign irq_o     = |(status_s & ien_q);

    // R2: output data only changes on a write to its offset.
    p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_out |=> $stable(pad_out));

    // R9: addresses past the last register read zero one cycle later.
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > OFS_MUX) |=> (bus_rdata == '0));

    // R7: with every line masked the interrupt stays low.
    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq_o);

    // R7: an interrupt needs at least one latched status bit.
    p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_s != '0));
endmodule

// File: tb/gpio_lvl_ctrl_tb_top.sv
module gpio_lvl_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] pad_in = '0;
    logic [11:0] pad_out, pad_oe;
    logic [31:0] mux_sel;
    logic        irq_o;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio_lvl_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .mux_sel(mux_sel), .irq_o(irq_o)
    );

    // Vector: write flag, address, data (write value or expected read), requirement.
    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 32'hFFFF_FFFF, 8'd2},  // R2 write output data
        '{1'b0, 8'h00, 32'h0000_0FFF, 8'd2},  // R2 upper bits read zero
        '{1'b1, 8'h04, 32'h0000_0A5A, 8'd2},  // R2 output enable
        '{1'b0, 8'h04, 32'h0000_0A5A, 8'd2},
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 8'd4},  // R4 polarity group 0, all low-active
        '{1'b0, 8'h10, 32'h1111_1111, 8'd4},
        '{1'b1, 8'h18, 32'hFFFF_FFFF, 8'd4},  // R4 polarity group 1
        '{1'b0, 8'h18, 32'h0000_1111, 8'd4},
        '{1'b0, 8'h0C, 32'h0000_0FFF, 8'd5},  // R5 low pins now active, masked (R7)
        '{1'b1, 8'h1C, 32'hDEAD_BEEF, 8'd8},  // R8 mux word
        '{1'b0, 8'h1C, 32'hDEAD_BEEF, 8'd8},
        '{1'b1, 8'h08, 32'hFFFF_FFFF, 8'd3},  // R3 write to input data ignored
        '{1'b0, 8'h08, 32'h0000_0000, 8'd3},
        '{1'b0, 8'h20, 32'h0000_0000, 8'd9},  // R9 unmapped
        '{1'b0, 8'h3C, 32'h0000_0000, 8'd9},
        '{1'b1, 8'h10, 32'h0000_0000, 8'd4},  // restore high-active polarity
        '{1'b1, 8'h18, 32'h0000_0000, 8'd4},
        '{1'b1, 8'h0C, 32'h0000_0FFF, 8'd6},  // R6 acknowledge all
        '{1'b0, 8'h0C, 32'h0000_0000, 8'd6}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_wr_en = 1'b0;
        @(negedge clk);
        chk(req, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pad_out", {20'b0, pad_out}, 32'h0);
        chk("R1 pad_oe", {20'b0, pad_oe}, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        chk("R1 mux_sel", mux_sel, 32'h0);
        bus_read(8'h0C, 32'h0, "R1 status");
        bus_read(8'h14, 32'h0, "R1 enable");

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
            else bus_read(VECS[i].addr, VECS[i].data, $sformatf("R%0d table[%0d]", VECS[i].req, i));
        end
        chk("R2 pad_out port", {20'b0, pad_out}, 32'h0000_0FFF);
        chk("R2 pad_oe port", {20'b0, pad_oe}, 32'h0000_0A5A);
        chk("R8 mux_sel port", mux_sel, 32'hDEAD_BEEF);
        chk("R7 masked irq", {31'b0, irq_o}, 32'h0);

        // R3 and R5: synchronised input, sticky after the pin drops
        pad_in = 12'h5A3;
        idle(3);
        bus_read(8'h08, 32'h0000_05A3, "R3 input data");
        bus_read(8'h0C, 32'h0000_05A3, "R5 status set");
        pad_in = 12'h000;
        idle(4);
        bus_read(8'h0C, 32'h0000_05A3, "R5 status sticky");
        bus_write(8'h0C, 32'h0000_0FFF);
        bus_read(8'h0C, 32'h0, "R6 cleared");

        // R6/R7: acknowledge while the source is still active
        bus_write(8'h14, 32'h0000_0008);
        pad_in = 12'h008;
        idle(4);
        chk("R7 irq unmasked", {31'b0, irq_o}, 32'h1);
        bus_write(8'h0C, 32'h0000_0000);
        chk("R6 write zero keeps", {31'b0, irq_o}, 32'h1);
        bus_write(8'h0C, 32'h0000_0008);
        chk("R6 clear edge", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R6 reassert", {31'b0, irq_o}, 32'h1);
        bus_write(8'h14, 32'h0);
        chk("R7 mask drops irq", {31'b0, irq_o}, 32'h0);
        bus_read(8'h0C, 32'h0000_0008, "R7 status kept while masked");
        pad_in = 12'h000;
        idle(3);
        bus_write(8'h0C, 32'h0000_0FFF);
        bus_read(8'h0C, 32'h0, "R6 clear after source gone");

        // R4: line 9 low-active via bit 4 of the second polarity register
        bus_write(8'h18, 32'h0000_0010);
        pad_in = 12'hFFF;
        idle(3);
        bus_write(8'h0C, 32'h0000_0FFF);
        bus_read(8'h0C, 32'h0000_0DFF, "R4 line9 low-active ignores high");
        pad_in = 12'hDFF;
        idle(3);
        bus_write(8'h0C, 32'h0000_0FFF);
        bus_read(8'h0C, 32'h0000_0FFF, "R4 line9 triggers low");
        pad_in = 12'h000;
        bus_write(8'h18, 32'h0);

        // R1: reset mid-run clears stored state
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pad_out after reset", {20'b0, pad_out}, 32'h0);
        chk("R1 mux after reset", mux_sel, 32'h0);
        bus_read(8'h18, 32'h0, "R1 polarity after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule